// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus side of a 2K x 8 serial memory that only ever acts as a slave on a two-wire bus. It oversamples SCL and SDA with the fast system clock and recognises start and stop conditions on the synchronised samples. It shifts in a device-select byte, a word-address byte and write data. It pulls SDA low to acknowledge and shifts read data out through an open-drain pull-down. An 11-bit address counter is built from three bits carried in the device-select byte and eight bits from the word-address byte.

Each accepted write byte goes to a separate page-write controller as a one-cycle valid strobe with its address. Read bytes come from a plain synchronous memory port that returns data one clock after the enable. The controller signals an internal write cycle on `wr_busy`. While it is high the block acknowledges nothing.

A read is started with a device-select byte whose last bit is 1. Bytes then stream out from the counter until the master leaves SDA high on the ninth clock. To read from a chosen address, the master writes the address and then issues a repeated start.

Top module: `serial_mem_slave`

## Requirements
- R1: While reset is high, and on the first cycle after it, the block releases SDA (`sda_pull_low` = 0) and raises no write strobe.
- R2: A falling SDA while SCL is high starts an address phase. A rising SDA while SCL is high returns the block to standby. In standby, bytes clocked without a start get no acknowledge.
- R3: The first byte after a start is received MSB first. Bits 7:4 must be 1010, bits 3:1 give address bits 10:8, and bit 0 selects a read (1) or a write (0). A matching byte is acknowledged by pulling SDA low for the whole ninth SCL pulse.
- R4: A device-select byte with a type code other than 1010 gets no acknowledge. No byte gets an acknowledge while `wr_busy` is high. In both cases the block ignores the bus until the next start.
- R5: In a write, the block acknowledges the word-address byte, which loads address bits 7:0. It acknowledges every data byte after it. Each data byte appears for exactly one cycle on `wr_valid`, with `wr_addr` set to the counter and `wr_data` set to the byte. The counter then advances by one.
- R6: In a read, the block sends bytes MSB first, starting at the counter. It advances the counter after each byte. The counter wraps from 7FFh to 000h and keeps its value between transfers.
- R7: If SDA is high on the ninth clock after a read byte (master no-acknowledge), the block stops sending and keeps SDA released until the next start.
- R8: A start in the middle of any byte abandons that byte and begins a fresh device-select phase.
- R9: Outside start and stop handling, the block changes its SDA pull-down only while the synchronised SCL is low.
- R10: `wr_valid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the wired bus |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_busy | input | 1 | Internal write cycle in progress |
| wr_valid | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr | output | 11 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| rd_en | output | 1 | Read enable to the memory |
| rd_addr | output | 11 | Read address |
| rd_data | input | 8 | Memory data, valid one cycle after rd_en |

## Verification
Each bus input passes two synchroniser flops and an edge register. The SDA pull-down therefore reacts on the third system edge after the SCL edge that caused it. The write strobe appears on that same edge after the eighth falling SCL of a data byte. The bench drives the bus in quarter-bit slots of ten system cycles and samples SDA only in the middle and at the end of each SCL high phase, well after any response is due. A read byte is fetched while the preceding acknowledge pulse is still running, and the memory returns it one cycle after the enable. The first bit is therefore ready when SCL falls. The scoreboard compares every write strobe whenever it occurs, and the bus tasks compare acknowledge bits and read bytes at their sample points.

// File: rtl/smem_pkg.sv
package smem_pkg;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int HI_W = AW - DW;
    localparam logic [3:0] TYPE_CODE = 4'b1010;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_MADDR, ST_WDATA, ST_SACK, ST_RDATA, ST_MACK
    } st_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic code_ok(logic [DW-1:0] b);
        return b[DW-1:DW-4] == TYPE_CODE;
    endfunction
endpackage

// File: rtl/smem_bus_sampler.sv
module smem_bus_sampler
    import smem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        ev.scl   = scl_sh[STAGES-1];
        ev.sda   = sda_sh[STAGES-1];
        ev.rise  = ev.scl & ~scl_q;
        ev.fall  = ~ev.scl & scl_q;
        ev.start = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop  = ev.scl & scl_q & ~sda_q & ev.sda;
    end
endmodule

// File: rtl/smem_addr_ctr.sv
module smem_addr_ctr
    import smem_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_hi,
    input  logic [HI_W-1:0] hi,
    input  logic            ld_lo,
    input  logic [DW-1:0]   lo,
    input  logic            inc,
    output logic [AW-1:0]   addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + ONE;
        end else begin
            if (ld_hi) addr[AW-1:DW] <= hi;
            if (ld_lo) addr[DW-1:0]  <= lo;
        end
    end

    // R6: counter wraps from the top address to zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && addr == {AW{1'b1}}) |=> addr == '0);
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import smem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pull_low,
    input  logic          wr_busy,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data
);
    bus_ev_t ev;
    st_t st, st_n, ack_next, ackn_n;
    logic [3:0] bitcnt, bit_n;
    logic [DW-1:0] shreg, sh_n, txreg, tx_n, rbuf;
    logic sda_oe, oe_n, rd_pend;
    logic ld_hi, ld_lo, inc, wv_n;
    logic [AW-1:0] addr;

    smem_bus_sampler #(.STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    smem_addr_ctr u_ctr (
        .clk(clk), .rst(rst),
        .ld_hi(ld_hi), .hi(shreg[HI_W:1]),
        .ld_lo(ld_lo), .lo(shreg),
        .inc(inc), .addr(addr)
    );

    always_comb begin
        st_n   = st;
        bit_n  = bitcnt;
        sh_n   = shreg;
        tx_n   = txreg;
        oe_n   = sda_oe;
        ackn_n = ack_next;
        ld_hi  = 1'b0;
        ld_lo  = 1'b0;
        inc    = 1'b0;
        wv_n   = 1'b0;
        if (ev.start) begin
            st_n  = ST_DEV;
            bit_n = '0;
            oe_n  = 1'b0;
        end else if (ev.stop) begin
            st_n = ST_IDLE;
            oe_n = 1'b0;
        end else begin
            case (st)
                ST_DEV, ST_MADDR, ST_WDATA: begin
                    if (ev.rise && bitcnt < BITS_PER_BYTE) begin
                        sh_n  = {shreg[DW-2:0], ev.sda};
                        bit_n = bitcnt + 4'd1;
                    end else if (ev.fall && bitcnt == BITS_PER_BYTE) begin
                        bit_n = '0;
                        if (wr_busy || (st == ST_DEV && !code_ok(shreg))) begin
                            st_n = ST_IDLE;
                        end else begin
                            st_n = ST_SACK;
                            oe_n = 1'b1;
                            if (st == ST_DEV) begin
                                ld_hi  = 1'b1;
                                ackn_n = shreg[0] ? ST_RDATA : ST_MADDR;
                            end else if (st == ST_MADDR) begin
                                ld_lo  = 1'b1;
                                ackn_n = ST_WDATA;
                            end else begin
                                wv_n   = 1'b1;
                                inc    = 1'b1;
                                ackn_n = ST_WDATA;
                            end
                        end
                    end
                end
                ST_SACK: begin
                    if (ev.fall) begin
                        st_n  = ack_next;
                        bit_n = '0;
                        oe_n  = 1'b0;
                        if (ack_next == ST_RDATA) begin
                            tx_n = rbuf;
                            oe_n = ~rbuf[DW-1];
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev.rise && bitcnt < BITS_PER_BYTE) begin
                        bit_n = bitcnt + 4'd1;
                    end else if (ev.fall) begin
                        if (bitcnt == BITS_PER_BYTE) begin
                            st_n  = ST_MACK;
                            oe_n  = 1'b0;
                            inc   = 1'b1;
                            bit_n = '0;
                        end else if (bitcnt != 4'd0) begin
                            tx_n = {txreg[DW-2:0], 1'b0};
                            oe_n = ~txreg[DW-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        if (ev.sda) st_n = ST_IDLE;
                        else        bit_n = 4'd1;
                    end else if (ev.fall && bitcnt == 4'd1) begin
                        st_n  = ST_RDATA;
                        bit_n = '0;
                        tx_n  = rbuf;
                        oe_n  = ~rbuf[DW-1];
                    end
                end
                default: ;
            endcase
        end
    end

    assign rd_en   = (st == ST_SACK && ack_next == ST_RDATA) || st == ST_MACK;
    assign rd_addr = addr;
    assign sda_pull_low = sda_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ack_next <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            rbuf     <= '0;
            sda_oe   <= 1'b0;
            rd_pend  <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            st       <= st_n;
            ack_next <= ackn_n;
            bitcnt   <= bit_n;
            shreg    <= sh_n;
            txreg    <= tx_n;
            sda_oe   <= oe_n;
            rd_pend  <= rd_en;
            if (rd_pend) rbuf <= rd_data;
            wr_valid <= wv_n;
            if (wv_n) begin
                wr_addr <= addr;
                wr_data <= shreg;
            end
        end
    end

    // R1: quiet bus side straight out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_pull_low && !wr_valid));
    // R2: a stop always leaves the block in standby with SDA released
    a_r2_stop_standby: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st == ST_IDLE && !sda_pull_low));
    // R4: nothing is acknowledged or forwarded while a write cycle runs
    a_r4_busy_nack: assert property (@(posedge clk) disable iff (rst)
        (wr_busy && ev.fall && bitcnt == BITS_PER_BYTE &&
         (st == ST_DEV || st == ST_MADDR || st == ST_WDATA))
        |=> (!sda_pull_low && !wr_valid));
    // R7: master no-acknowledge ends the read
    a_r7_nack_idle: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MACK && ev.rise && ev.sda && !ev.start && !ev.stop)
        |=> (st == ST_IDLE && !sda_pull_low));
    // R9: pull-down holds still while SCL is high
    a_r9_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && !ev.start && !ev.stop) |=> $stable(sda_oe));
    // R10: write strobe is a single-cycle pulse
    a_r10_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);
endmodule

// File: tb/test_serial_mem_slave.sv
module test_serial_mem_slave;
    localparam int Q = 10;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic wr_busy = 1'b0;
    logic sda_pull_low, wr_valid, rd_en;
    logic [10:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic sda_bus;
    logic [7:0] dmem [0:2047];
    logic [7:0] emem [0:2047];
    logic [18:0] exp_q [$];
    int checks = 0, errors = 0;
    logic prev_wv = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull_low;

    serial_mem_slave i_serial_mem_slave (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_low(sda_pull_low), .wr_busy(wr_busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] init_val(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    always @(posedge clk) begin
        if (wr_valid) dmem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= dmem[rd_addr];
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                if (exp_q.size() == 0) check("R5 unexpected write strobe", 1, 0);
                else begin
                    logic [18:0] it;
                    it = exp_q.pop_front();
                    check("R5 write address", int'(wr_addr), int'(it[18:8]));
                    check("R5 write data", int'(wr_data), int'(it[7:0]));
                end
                if (prev_wv) check("R10 strobe width", 2, 1);
            end
            prev_wv <= wr_valid;
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        logic b1;
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b1 = sda_bus; wq();
        b = sda_bus;
        m_scl = 1'b0;
        check("R9 SDA steady while SCL high", int'(b), int'(b1));
        wq();
    endtask

    task automatic send_byte(logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = !a;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic mack);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(!mack);
    endtask

    task automatic write_data(logic [10:0] a, logic [7:0] v, string req);
        logic ak;
        exp_q.push_back({a, v});
        emem[a] = v;
        send_byte(v, ak);
        check(req, int'(ak), 1);
    endtask

    task automatic set_addr(logic [10:0] a);
        logic ak;
        do_start();
        send_byte({4'b1010, a[10:8], 1'b0}, ak);
        check("R3 device-select ack", int'(ak), 1);
        send_byte(a[7:0], ak);
        check("R5 word-address ack", int'(ak), 1);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            dmem[i] = init_val(i);
            emem[i] = init_val(i);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check("watchdog expired", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] d;
        logic bt;
        repeat (4) @(negedge clk);
        check("R1 SDA released in reset", int'(sda_pull_low), 0);
        check("R1 no write strobe in reset", int'(wr_valid), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 SDA released after reset", int'(sda_pull_low), 0);

        // page of three bytes at 234h
        set_addr(11'h234);
        write_data(11'h234, 8'hAA, "R5 data ack 1");
        write_data(11'h235, 8'h55, "R5 data ack 2");
        write_data(11'h236, 8'h0F, "R5 data ack 3");
        do_stop();
        wq();

        // random read back through repeated start
        set_addr(11'h234);
        do_start();
        send_byte(8'b1010_010_1, ak);
        check("R3 read select ack", int'(ak), 1);
        read_byte(d, 1'b1); check("R6 read 234h", int'(d), int'(emem[11'h234]));
        read_byte(d, 1'b1); check("R6 read 235h", int'(d), int'(emem[11'h235]));
        read_byte(d, 1'b0); check("R6 read 236h", int'(d), int'(emem[11'h236]));
        check("R7 SDA released after master nack", int'(sda_pull_low), 0);
        for (int i = 0; i < 8; i++) begin
            recv_bit(bt);
            check("R7 silent after nack", int'(bt), 1);
        end
        do_stop();

        // current-address read continues at 237h
        do_start();
        send_byte(8'b1010_010_1, ak);
        check("R3 current read ack", int'(ak), 1);
        read_byte(d, 1'b0); check("R6 counter kept 237h", int'(d), int'(emem[11'h237]));
        do_stop();

        // wrap across the top of memory
        set_addr(11'h7FE);
        do_start();
        send_byte(8'b1010_111_1, ak);
        check("R3 high bits select ack", int'(ak), 1);
        read_byte(d, 1'b1); check("R6 read 7FEh", int'(d), int'(emem[11'h7FE]));
        read_byte(d, 1'b1); check("R6 read 7FFh", int'(d), int'(emem[11'h7FF]));
        read_byte(d, 1'b0); check("R6 wrap to 000h", int'(d), int'(emem[0]));
        do_stop();

        // wrong type code
        do_start();
        send_byte(8'b1011_000_0, ak);
        check("R4 wrong code nack", int'(ak), 0);
        send_byte(8'h12, ak);
        check("R4 ignored until start", int'(ak), 0);
        do_stop();

        // busy on device select
        wr_busy = 1'b1;
        do_start();
        send_byte(8'b1010_000_0, ak);
        check("R4 busy select nack", int'(ak), 0);
        do_stop();
        wr_busy = 1'b0;

        // busy on word address
        do_start();
        send_byte(8'b1010_000_0, ak);
        check("R3 select ack before busy", int'(ak), 1);
        wr_busy = 1'b1;
        send_byte(8'h40, ak);
        check("R4 busy address nack", int'(ak), 0);
        wr_busy = 1'b0;
        do_stop();

        // standby after stop
        send_byte(8'hA0, ak);
        check("R2 no ack without start", int'(ak), 0);
        do_stop();

        // start in the middle of a byte
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        do_start();
        send_byte(8'b1010_001_0, ak);
        check("R8 select after aborted byte", int'(ak), 1);
        send_byte(8'h10, ak);
        check("R8 address after restart", int'(ak), 1);
        write_data(11'h110, 8'h5A, "R8 data after restart");
        do_stop();

        // read back the restarted write
        set_addr(11'h110);
        do_start();
        send_byte(8'b1010_001_1, ak);
        check("R3 select ack for readback", int'(ak), 1);
        read_byte(d, 1'b0); check("R8 readback 110h", int'(d), 8'h5A);
        do_stop();
        wq();

        check("R5 all expected writes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule